// File: doc/BRIEF.md
# SD Data-Line Block Write Engine

This engine moves one or more fixed-length data blocks from a byte-wide source onto the data lines of a memory card. It can use one line or four. Each block goes out framed: a low start bit, then the payload, then a 16-bit CRC and a high end bit, on every line in use. Each line carries its own CRC. Once the end bit is out, the engine releases the lines and listens on DAT0. There it waits for the card's three-bit status token, and then for the card to stop holding the line low while it programs. Each block ends with a one-cycle completion pulse and a status code: accepted, rejected or timed out. The whole transfer ends with one final pulse.

The engine moves one bus bit per cycle in which the `tick` strobe is high. Between strobes it holds its state and its outputs. The card clock, command traffic and responses are handled elsewhere. Software loads the width, the block length, the block count and the timeout limit, then pulses `start`. The engine latches these settings at `start`.

Top module: `sd_blkwr`

## Requirements
- R1: On each line in use, a block is sent in this order: one low start bit, the data bits of `blk_len` bytes (most significant bit first), 16 CRC bits (most significant first), then one high end bit. Each bit is held for one tick period.
- R2: With `wide4`=0, only DAT0 is driven (`dat_oe`=0001). With `wide4`=1, all four lines are driven (`dat_oe`=1111). In four-line mode each byte goes out as its high nibble and then its low nibble, with nibble bit k on DATk. The width is captured at `start`, so later changes to `wide4` do not affect a running transfer.
- R3: The CRC on each line is the CRC-16 with polynomial 0x1021 and a start value of zero. It covers only that line's data bits.
- R4: From reset, and from the tick after the end bit until the start bit of the next block, `dat_oe` is 0000. When idle, `busy` and `byte_ready` are low.
- R5: The token is a low start bit followed by three bits, with the first received bit as the MSB. The pattern 010 accepts the block. Any other pattern (101 or otherwise) ends the transfer at once with status 01, and no further block is sent.
- R6: After an accepted token, neither the next block's start bit nor the final completion happens until DAT0 is sampled high on a tick.
- R7: The timeout counts ticks that sample DAT0 high while the engine waits for the token start bit, or ticks that sample DAT0 low during the busy period. When that count reaches `tmo_limit`, the engine reports status 10 and ends the transfer.
- R8: A transfer sends `blk_cnt` blocks when every block is accepted. It gives one `blk_done` pulse per block and a single `xfer_done` pulse, coincident with the last `blk_done`, and takes exactly `blk_cnt`×`blk_len` bytes through the valid/ready handshake.
- R9: A `start` pulse while `busy` is high is ignored.
- R10: `dat_out` and `dat_oe` change only in the cycle after a tick, and `blk_done` follows a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe, one per bus bit period |
| start | input | 1 | Begins a transfer when idle |
| wide4 | input | 1 | 1 = four data lines, 0 = DAT0 only |
| blk_len | input | LEN_W | Payload bytes per block (at least 1) |
| blk_cnt | input | CNT_W | Blocks per transfer (at least 1) |
| tmo_limit | input | TMO_W | Tick limit for token wait and busy period |
| byte_data | input | 8 | Source byte |
| byte_valid | input | 1 | Source byte valid |
| byte_ready | output | 1 | Engine accepts a byte this cycle |
| dat_out | output | 4 | Data line drive values, bit k = DATk |
| dat_oe | output | 4 | Per-line output enable |
| dat_in | input | 4 | Data line levels seen from the card |
| busy | output | 1 | Transfer in progress |
| blk_done | output | 1 | One-cycle pulse at the end of each block |
| blk_stat | output | 2 | Block status: 00 accepted, 01 rejected, 10 timeout |
| xfer_done | output | 1 | One-cycle pulse at the end of the transfer |

## Verification
All engine outputs are registered on the clock edge where a tick is sampled. A bit driven on that edge is therefore valid from the following falling edge until the next tick edge. `blk_done`, `blk_stat` and `xfer_done` are visible for exactly the one cycle after the deciding tick. The bench keeps to this timing by doing all of its sampling and driving on falling edges. It records line values only on the falling edge right after a tick edge. It changes the card's DAT0 level at those same falling edges, so the engine samples each scripted token or busy element on exactly one tick. That makes the timeout boundaries exact: a gap of 6 passes and a gap of 7 times out, and 7 busy ticks pass while 8 time out.

// File: rtl/sd_blkwr_pkg.sv
package sd_blkwr_pkg;
    localparam int LANES = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_DATA, S_CRC, S_END,
        S_WTOK, S_TOK, S_TEND, S_BUSY
    } wr_st_e;

    localparam logic [1:0] STAT_OK  = 2'b00;
    localparam logic [1:0] STAT_CRC = 2'b01;
    localparam logic [1:0] STAT_TMO = 2'b10;

    localparam logic [2:0] TOK_ACCEPT = 3'b010;
endpackage

// File: rtl/sd_blkwr_crc16.sv
// One line's CRC-16: updates with a data bit, or shifts out toward msb.
module sd_blkwr_crc16 #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic shf,
    input  logic din,
    output logic msb
);
    logic [15:0] crc_d, crc_q;
    logic        fb;

    always_comb begin
        fb    = din ^ crc_q[15];
        crc_d = crc_q;
        if (clr)
            crc_d = '0;
        else if (upd)
            crc_d = {crc_q[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
        else if (shf)
            crc_d = {crc_q[14:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign msb = crc_q[15];
endmodule

// File: rtl/sd_blkwr_tmr.sv
// Tick counter that flags when an incremented count reaches the limit.
module sd_blkwr_tmr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = nxt[W-1:0];
    end

    assign hit = inc && !clr && (nxt >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sd_blkwr.sv
module sd_blkwr
    import sd_blkwr_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int CNT_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             wide4,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [CNT_W-1:0] blk_cnt,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic [7:0]       byte_data,
    input  logic             byte_valid,
    output logic             byte_ready,
    output logic [3:0]       dat_out,
    output logic [3:0]       dat_oe,
    input  logic [3:0]       dat_in,
    output logic             busy,
    output logic             blk_done,
    output logic [1:0]       blk_stat,
    output logic             xfer_done
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [3:0]       CRC_LAST = 4'd15;

    typedef struct packed {
        wr_st_e           st;
        logic             wide;
        logic [LEN_W-1:0] len_cfg;
        logic [LEN_W-1:0] len_left;
        logic [CNT_W-1:0] blk_left;
        logic [2:0]       slice;
        logic [7:0]       sh;
        logic [7:0]       buf_b;
        logic             buf_full;
        logic [3:0]       bitcnt;
        logic [2:0]       tok;
        logic [3:0]       out;
        logic [3:0]       oe;
        logic             done;
        logic             xdone;
        logic [1:0]       stat;
    } regs_t;

    regs_t r_d, r_q;

    logic             crc_clr, crc_upd, crc_shf;
    logic [LANES-1:0] crc_din, crc_msb;
    logic             tmr_clr, tmr_inc, tmr_hit;

    // Per-line CRC generators
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sd_blkwr_crc16 u_crc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (crc_clr),
            .upd   (crc_upd),
            .shf   (crc_shf),
            .din   (crc_din[l]),
            .msb   (crc_msb[l])
        );
    end

    sd_blkwr_tmr #(.W(TMO_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .limit (tmo_limit),
        .hit   (tmr_hit)
    );

    assign byte_ready = !r_q.buf_full &&
                        ((r_q.st == S_LOAD) ||
                         ((r_q.st == S_DATA) && ((r_q.slice == 3'd0) || (r_q.len_left > LEN_ONE))));

    logic [7:0] cur;
    logic       last;
    logic       fin;
    logic [1:0] fin_stat;

    always_comb begin
        r_d      = r_q;
        r_d.done  = 1'b0;
        r_d.xdone = 1'b0;
        crc_clr  = 1'b0;
        crc_upd  = 1'b0;
        crc_shf  = 1'b0;
        crc_din  = '0;
        tmr_clr  = 1'b0;
        tmr_inc  = 1'b0;
        cur      = 8'h00;
        last     = 1'b0;
        fin      = 1'b0;
        fin_stat = STAT_OK;

        if (byte_valid && byte_ready) begin
            r_d.buf_b    = byte_data;
            r_d.buf_full = 1'b1;
        end

        case (r_q.st)
            S_IDLE: if (start) begin
                r_d.wide     = wide4;
                r_d.len_cfg  = blk_len;
                r_d.blk_left = blk_cnt;
                r_d.st       = S_LOAD;
            end
            S_LOAD: if (tick) begin
                r_d.out      = 4'b0000;
                r_d.oe       = r_q.wide ? 4'b1111 : 4'b0001;
                r_d.len_left = r_q.len_cfg;
                r_d.slice    = 3'd0;
                crc_clr      = 1'b1;
                r_d.st       = S_DATA;
            end
            S_DATA: if (tick && (r_q.slice != 3'd0 || r_q.buf_full)) begin
                cur = (r_q.slice == 3'd0) ? r_q.buf_b : r_q.sh;
                if (r_q.slice == 3'd0) r_d.buf_full = 1'b0;
                crc_upd = 1'b1;
                if (r_q.wide) begin
                    r_d.out = cur[7:4];
                    crc_din = cur[7:4];
                    r_d.sh  = {cur[3:0], 4'h0};
                    last    = (r_q.slice == 3'd1);
                end else begin
                    r_d.out = {3'b111, cur[7]};
                    crc_din = {3'b000, cur[7]};
                    r_d.sh  = {cur[6:0], 1'b0};
                    last    = (r_q.slice == 3'd7);
                end
                r_d.slice = last ? 3'd0 : r_q.slice + 3'd1;
                if (last) begin
                    if (r_q.len_left == LEN_ONE) begin
                        r_d.st     = S_CRC;
                        r_d.bitcnt = 4'd0;
                    end else begin
                        r_d.len_left = r_q.len_left - LEN_ONE;
                    end
                end
            end
            S_CRC: if (tick) begin
                crc_shf    = 1'b1;
                r_d.out    = r_q.wide ? crc_msb : {3'b111, crc_msb[0]};
                r_d.bitcnt = r_q.bitcnt + 4'd1;
                if (r_q.bitcnt == CRC_LAST) r_d.st = S_END;
            end
            S_END: if (tick) begin
                r_d.out = 4'b1111;
                tmr_clr = 1'b1;
                r_d.st  = S_WTOK;
            end
            S_WTOK: if (tick) begin
                r_d.oe = 4'b0000;
                if (!dat_in[0]) begin
                    r_d.st     = S_TOK;
                    r_d.bitcnt = 4'd0;
                end else begin
                    tmr_inc = 1'b1;
                    if (tmr_hit) begin
                        fin      = 1'b1;
                        fin_stat = STAT_TMO;
                    end
                end
            end
            S_TOK: if (tick) begin
                r_d.tok    = {r_q.tok[1:0], dat_in[0]};
                r_d.bitcnt = r_q.bitcnt + 4'd1;
                if (r_q.bitcnt == 4'd2) r_d.st = S_TEND;
            end
            S_TEND: if (tick) begin
                if (r_q.tok == TOK_ACCEPT) begin
                    tmr_clr = 1'b1;
                    r_d.st  = S_BUSY;
                end else begin
                    fin      = 1'b1;
                    fin_stat = STAT_CRC;
                end
            end
            S_BUSY: if (tick) begin
                if (dat_in[0]) begin
                    fin      = 1'b1;
                    fin_stat = STAT_OK;
                end else begin
                    tmr_inc = 1'b1;
                    if (tmr_hit) begin
                        fin      = 1'b1;
                        fin_stat = STAT_TMO;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (fin) begin
            r_d.done = 1'b1;
            r_d.stat = fin_stat;
            if (fin_stat == STAT_OK && r_q.blk_left > CNT_ONE) begin
                r_d.blk_left = r_q.blk_left - CNT_ONE;
                r_d.st       = S_LOAD;
            end else begin
                r_d.xdone = 1'b1;
                r_d.st    = S_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dat_out   = r_q.out;
    assign dat_oe    = r_q.oe;
    assign busy      = (r_q.st != S_IDLE);
    assign blk_done  = r_q.done;
    assign blk_stat  = r_q.stat;
    assign xfer_done = r_q.xdone;
endmodule

// File: rtl/sd_blkwr_chk.sv
module sd_blkwr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       busy,
    input logic [3:0] dat_out,
    input logic [3:0] dat_oe,
    input logic [3:0] dat_in,
    input logic       byte_ready,
    input logic       blk_done,
    input logic [1:0] blk_stat,
    input logic       xfer_done
);
    // R10
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(dat_out) && $stable(dat_oe)));

    // R10
    done_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> $past(tick));

    // R2
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_oe == 4'b0000) || (dat_oe == 4'b0001) || (dat_oe == 4'b1111));

    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dat_oe == 4'b0000));

    // R4
    idle_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> busy);

    // R6
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && blk_stat == 2'b00) |-> ($past(tick) && $past(dat_in[0])));

    // R8
    final_with_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> blk_done);

    // R7
    stat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (blk_stat != 2'b11));
endmodule

bind sd_blkwr sd_blkwr_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .busy       (busy),
    .dat_out    (dat_out),
    .dat_oe     (dat_oe),
    .dat_in     (dat_in),
    .byte_ready (byte_ready),
    .blk_done   (blk_done),
    .blk_stat   (blk_stat),
    .xfer_done  (xfer_done)
);

// File: tb/sd_blkwr_tb.sv
`timescale 1ns/1ps
module sd_blkwr_tb_top;
    localparam int LEN_W = 12;
    localparam int CNT_W = 8;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             start = 1'b0;
    logic             wide4 = 1'b0;
    logic [LEN_W-1:0] blk_len = '0;
    logic [CNT_W-1:0] blk_cnt = '0;
    logic [TMO_W-1:0] tmo_limit = TMO_W'(8);
    logic [7:0]       byte_data = 8'h00;
    logic             byte_valid = 1'b0;
    logic             byte_ready;
    logic [3:0]       dat_out, dat_oe;
    logic [3:0]       dat_in = 4'b1111;
    logic             busy, blk_done, xfer_done;
    logic [1:0]       blk_stat;

    always #5 clk = ~clk;

    sd_blkwr #(.LEN_W(LEN_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .wide4(wide4),
        .blk_len(blk_len), .blk_cnt(blk_cnt), .tmo_limit(tmo_limit),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .dat_out(dat_out), .dat_oe(dat_oe), .dat_in(dat_in), .busy(busy),
        .blk_done(blk_done), .blk_stat(blk_stat), .xfer_done(xfer_done)
    );

    int checks = 0;
    int fails  = 0;

    // bench state shared by the falling-edge process and the tasks
    int   cyc = 0, tcnt = 0;
    bit   take_pend = 0;
    int   src_idx = 0;
    int   ndone = 0, nxfer = 0, fr = 0, pos = 0, oe_bad = 0, viol = 0;
    logic [1:0] dstat [0:15];
    int   flen [0:3];
    logic cap [0:3][0:3][0:95];
    logic [3:0] exp_mask = 4'b0001;
    bit   prev_oe_nz = 0;
    bit   card_run = 0;
    int   cidx = 0, scr_len = 0;
    logic scr [0:63];

    function automatic logic [7:0] pay(input int i);
        return 8'((i * 29 + 7) ^ (i >> 2));
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Falling-edge process: tick strobe, byte source, recording, card model.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
        if (take_pend) src_idx++;
        byte_data = pay(src_idx);
        take_pend = byte_ready && byte_valid;

        if (blk_done) begin
            if (ndone < 16) dstat[ndone] = blk_stat;
            ndone++;
            if (blk_stat == 2'b00 && card_run && cidx < scr_len - 1) viol++;
        end
        if (xfer_done) nxfer++;

        if (tick) begin
            if (dat_oe != 4'b0000) begin
                if (!prev_oe_nz && card_run && cidx < scr_len - 1) viol++;
                if (dat_oe != exp_mask) oe_bad++;
                if (fr < 4 && pos < 96)
                    for (int l = 0; l < 4; l++) cap[fr][l][pos] = dat_out[l];
                pos++;
            end else if (prev_oe_nz) begin
                if (fr < 4) flen[fr] = pos;
                fr++;
                pos = 0;
                card_run = 1;
                cidx = 0;
                dat_in = {3'b111, scr[0]};
            end else if (card_run) begin
                cidx++;
                if (cidx < scr_len) dat_in = {3'b111, scr[cidx]};
                else begin
                    card_run = 0;
                    dat_in = 4'b1111;
                end
            end
            prev_oe_nz = (dat_oe != 4'b0000);
        end
        tick = (tcnt == 2);
        tcnt = (tcnt + 1) % 4;
    end

    // One transfer with a scripted card reply; checks its own results.
    task automatic run_xfer(input string name, input bit w, input int len, input int nblk,
                            input int gap, input logic [2:0] tk, input int nbusy,
                            input logic [1:0] es, input int eblk, input bit poke);
        int base, t, n, lanes, errs, bad_at;
        logic [7:0] v;
        logic [15:0] c;
        logic eb [0:95];
        @(posedge clk);
        scr_len = 0;
        for (int i = 0; i < gap; i++) begin scr[scr_len] = 1'b1; scr_len++; end
        scr[scr_len] = 1'b0; scr_len++;
        for (int i = 2; i >= 0; i--) begin scr[scr_len] = tk[i]; scr_len++; end
        scr[scr_len] = 1'b1; scr_len++;
        for (int i = 0; i < nbusy; i++) begin scr[scr_len] = 1'b0; scr_len++; end
        scr[scr_len] = 1'b1; scr_len++;
        exp_mask = w ? 4'b1111 : 4'b0001;
        fr = 0; pos = 0; ndone = 0; nxfer = 0; oe_bad = 0; viol = 0;
        base = src_idx + (take_pend ? 1 : 0);
        @(negedge clk);
        wide4 = w;
        blk_len = LEN_W'(len);
        blk_cnt = CNT_W'(nblk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            wide4 = ~w;                       // R2 width latched at start
            repeat (60) @(negedge clk);
            start = 1'b1;                     // R9 start ignored while busy
            blk_len = LEN_W'(len + 3);
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (nxfer == 0 && t < 30000) begin @(negedge clk); t++; end
        repeat (400) @(negedge clk);
        wide4 = w;

        chk(nxfer == 1, "R8", {name, " xfer_done pulses"}, nxfer, 1);
        chk(ndone == eblk, (es == 2'b00) ? "R8" : "R5 R7", {name, " blk_done pulses"}, ndone, eblk);
        if (ndone >= 1 && ndone <= 16)
            chk(dstat[ndone-1] == es, (es == 2'b10) ? "R7" : "R5", {name, " final status"},
                int'(dstat[ndone-1]), int'(es));
        chk(src_idx - base == eblk * len, "R8", {name, " bytes taken"}, src_idx - base, eblk * len);
        chk(fr == eblk, "R4", {name, " line release count"}, fr, eblk);
        chk(oe_bad == 0, "R2", {name, " lines driven vs width"}, oe_bad, 0);
        if (es == 2'b00)
            chk(viol == 0, "R6", {name, " action before busy release"}, viol, 0);

        lanes = w ? 4 : 1;
        for (int b = 0; b < eblk && b < 4; b++) begin
            for (int l = 0; l < lanes; l++) begin
                n = 0; c = 16'h0000;
                eb[n] = 1'b0; n++;
                for (int j = 0; j < len; j++) begin
                    v = pay(base + b * len + j);
                    for (int k = 0; k < (w ? 2 : 8); k++) begin
                        logic bt;
                        bt = w ? v[(k == 0 ? 4 : 0) + l] : v[7 - k];
                        eb[n] = bt; n++;
                        c = {c[14:0], 1'b0} ^ ((bt ^ c[15]) ? 16'h1021 : 16'h0000);
                    end
                end
                for (int k = 15; k >= 0; k--) begin eb[n] = c[k]; n++; end
                eb[n] = 1'b1; n++;
                errs = 0; bad_at = -1;
                for (int i = 0; i < n; i++)
                    if (cap[b][l][i] !== eb[i]) begin errs++; if (bad_at < 0) bad_at = i; end
                chk(flen[b] == n, "R1", {name, " frame length"}, flen[b], n);
                chk(errs == 0, w ? "R1 R2 R3" : "R1 R3", {name, " frame bits, first bad index"}, bad_at, -1);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && dat_oe == 4'b0000, "R4", "reset busy/oe", {busy, dat_oe}, 0);
        chk(byte_ready == 1'b0 && blk_done == 1'b0 && xfer_done == 1'b0, "R4", "reset ready/done",
            {byte_ready, blk_done, xfer_done}, 0);
        rst_n = 1'b1;
        byte_valid = 1'b1;
        repeat (8) @(negedge clk);
        chk(busy == 1'b0 && dat_oe == 4'b0000, "R4", "idle after reset", {busy, dat_oe}, 0);

        run_xfer("one_line",    1'b0, 4, 1, 6, 3'b010, 3, 2'b00, 1, 1'b1);
        run_xfer("four_line",   1'b1, 8, 1, 2, 3'b010, 7, 2'b00, 1, 1'b0);
        run_xfer("multi_four",  1'b1, 4, 3, 1, 3'b010, 4, 2'b00, 3, 1'b1);
        run_xfer("multi_nobsy", 1'b0, 1, 2, 0, 3'b010, 0, 2'b00, 2, 1'b0);
        run_xfer("crc_reject",  1'b0, 2, 2, 1, 3'b101, 2, 2'b01, 1, 1'b0);
        run_xfer("bad_token",   1'b1, 3, 2, 1, 3'b111, 2, 2'b01, 1, 1'b0);
        run_xfer("tok_timeout", 1'b0, 2, 2, 7, 3'b010, 2, 2'b10, 1, 1'b0);
        run_xfer("bsy_timeout", 1'b1, 2, 2, 1, 3'b010, 8, 2'b10, 1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule